// File: doc/BRIEF.md
# Spare-Word Lookup and Bit Merge Table

This block sits beside a memory array in a stacked-memory repair path. It keeps a small table of known fault locations. Each location is given as a layer, an array inside that layer, a row and a column word address. With each location the table also keeps a mapped-layer index, a bit mask of the faulty cells in that word, and a spare word holding the correct contents of those cells. A self-test collector loads fault locations one after another into the next free slot. A write path keeps the spare contents up to date. An analysis engine reads each entry and marks it as needing a spare row or a spare column.

Every read request is looked up in the table in the same cycle that the request goes to the main array. One cycle later the array returns its word, and the block delivers the repaired word. On a miss the array word passes through unchanged. On a hit only the bits picked by the entry's mask are taken from the spare word; every other bit comes from the array.

Top module: `spare_merge_cam`

## Requirements
- R1: After reset no entry is valid, `full` is 0, `out_valid` and `out_hit` are 0, and every entry reads back with valid, row-must, column-must and mapped layer all 0.
- R2: One cycle after a read whose address matches no valid entry, `out_hit` is 0 and `out_data` equals `arr_data` bit for bit.
- R3: One cycle after a read that hits, `out_data` is `(arr_data & ~mask) | (spare & mask)`, where mask and spare belong to the matched entry, and `out_hit` is 1.
- R4: A read hits an entry only if layer, array, row and column all match that entry and the entry is valid. The mapped-layer field takes no part in the match.
- R5: When several valid entries match, the entry with the lowest index supplies the mask and spare word. This applies to reads and to spare-data writes.
- R6: A load fills entries in order from index 0. `full` goes to 1 once all DEPTH entries are valid. A load while `full` is 1 changes no entry.
- R7: A spare-data write replaces the spare word of the lowest-index matching valid entry from the next cycle on. A read in the same cycle still sees the old word. A write that matches no entry changes nothing.
- R8: The readout port shows valid, row-must, column-must and mapped layer of entry `fl_idx`. A load sets these fields. `fl_set_rmf`/`fl_set_cmf` set the flag of entry `fl_idx` to 1 from the next cycle on.
- R9: A freshly loaded entry has an all-zero spare word until it is written.
- R10: `out_valid` is 1 exactly in the cycle after a cycle with `rd_valid` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load a fault location into the next free entry |
| ld_layer | input | LAYER_W | Layer of the fault |
| ld_array | input | ARRAY_W | Array index of the fault |
| ld_row | input | ROW_W | Row of the fault |
| ld_col | input | COL_W | Column word of the fault |
| ld_mlayer | input | LAYER_W | Mapped-layer index stored with the entry |
| ld_mask | input | DATA_W | Faulty bit positions inside the word |
| ld_rmf | input | 1 | Initial row-must flag |
| ld_cmf | input | 1 | Initial column-must flag |
| full | output | 1 | All entries are in use |
| rd_valid | input | 1 | Read request |
| rd_layer | input | LAYER_W | Read layer |
| rd_array | input | ARRAY_W | Read array index |
| rd_row | input | ROW_W | Read row |
| rd_col | input | COL_W | Read column word |
| arr_data | input | DATA_W | Word from the main array, valid the cycle after the request |
| out_valid | output | 1 | Repaired word available |
| out_hit | output | 1 | The request matched an entry |
| out_data | output | DATA_W | Repaired word |
| wr_valid | input | 1 | Spare-data write |
| wr_layer | input | LAYER_W | Write layer |
| wr_array | input | ARRAY_W | Write array index |
| wr_row | input | ROW_W | Write row |
| wr_col | input | COL_W | Write column word |
| wr_data | input | DATA_W | New spare word |
| fl_idx | input | IDX_W | Entry picked for flag readout and flag setting |
| fl_set_rmf | input | 1 | Set the row-must flag of entry fl_idx |
| fl_set_cmf | input | 1 | Set the column-must flag of entry fl_idx |
| fl_valid | output | 1 | Valid bit of entry fl_idx |
| fl_rmf | output | 1 | Row-must flag of entry fl_idx |
| fl_cmf | output | 1 | Column-must flag of entry fl_idx |
| fl_mlayer | output | LAYER_W | Mapped-layer index of entry fl_idx |

## Verification
A read's hit flag and repaired word are due exactly one clock edge after the request. The array word must be presented in that later cycle, and the bench holds it steady until the result is sampled. Loads, spare writes and flag sets take effect at the next edge, so `full` and the flag readout change one cycle after the stimulus. A read issued alongside a write or load sees the table as it stood before that edge. The bench steps its reference model at each rising edge, using the table state from before that edge. It then compares every output on the following falling edge, so each result is checked in the cycle it becomes due.

// File: rtl/rcam_pkg.sv
package rcam_pkg;

   // Per-entry status bits kept alongside each stored location.
   typedef struct packed {
      logic valid;
      logic rmf;
      logic cmf;
   } rcam_flags_t;

endpackage

// File: rtl/rcam_match.sv
// Parallel key compare against every stored entry.
module rcam_match #(
   parameter int DEPTH = 8,
   parameter int KEY_W = 29
) (
   input  logic [KEY_W-1:0]            key,
   input  logic [DEPTH-1:0][KEY_W-1:0] keys,
   input  logic [DEPTH-1:0]            valid,
   output logic [DEPTH-1:0]            hits
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hits[i] = valid[i] && (keys[i] == key);
   end

endmodule

// File: rtl/rcam_prio.sv
// Lowest-index-wins one-hot selection.
module rcam_prio #(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant,
   output logic             any
);

   always_comb begin
      grant = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
      any = |req;
   end

endmodule

// File: rtl/rcam_merge.sv
// Masked bit replacement of the array word.
module rcam_merge #(
   parameter int DATA_W = 16
) (
   input  logic              hit,
   input  logic [DATA_W-1:0] arr_word,
   input  logic [DATA_W-1:0] spare_word,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] merged
);

   always_comb begin
      if (hit) merged = (arr_word & ~mask) | (spare_word & mask);
      else     merged = arr_word;
   end

endmodule

// File: rtl/spare_merge_cam.sv
module spare_merge_cam
   import rcam_pkg::*;
#(
   parameter int LAYER_W = 3,
   parameter int ARRAY_W = 6,
   parameter int ROW_W   = 10,
   parameter int COL_W   = 10,
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 8,
   parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_valid,
   input  logic [LAYER_W-1:0] ld_layer,
   input  logic [ARRAY_W-1:0] ld_array,
   input  logic [ROW_W-1:0]   ld_row,
   input  logic [COL_W-1:0]   ld_col,
   input  logic [LAYER_W-1:0] ld_mlayer,
   input  logic [DATA_W-1:0]  ld_mask,
   input  logic               ld_rmf,
   input  logic               ld_cmf,
   output logic               full,
   input  logic               rd_valid,
   input  logic [LAYER_W-1:0] rd_layer,
   input  logic [ARRAY_W-1:0] rd_array,
   input  logic [ROW_W-1:0]   rd_row,
   input  logic [COL_W-1:0]   rd_col,
   input  logic [DATA_W-1:0]  arr_data,
   output logic               out_valid,
   output logic               out_hit,
   output logic [DATA_W-1:0]  out_data,
   input  logic               wr_valid,
   input  logic [LAYER_W-1:0] wr_layer,
   input  logic [ARRAY_W-1:0] wr_array,
   input  logic [ROW_W-1:0]   wr_row,
   input  logic [COL_W-1:0]   wr_col,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [IDX_W-1:0]   fl_idx,
   input  logic               fl_set_rmf,
   input  logic               fl_set_cmf,
   output logic               fl_valid,
   output logic               fl_rmf,
   output logic               fl_cmf,
   output logic [LAYER_W-1:0] fl_mlayer
);

   localparam int KEY_W = LAYER_W + ARRAY_W + ROW_W + COL_W;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spare_merge_cam: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("spare_merge_cam: DATA_W must be positive");
   end
   if ((1 << IDX_W) < DEPTH) begin : g_bad_idx
      $error("spare_merge_cam: IDX_W too narrow for DEPTH");
   end

   // Entry storage
   logic [KEY_W-1:0]   e_key   [DEPTH];
   logic [LAYER_W-1:0] e_ml    [DEPTH];
   logic [DATA_W-1:0]  e_mask  [DEPTH];
   logic [DATA_W-1:0]  e_spare [DEPTH];
   rcam_flags_t        e_flg   [DEPTH];
   logic [CNT_W-1:0]   fill_cnt;

   logic [DEPTH-1:0][KEY_W-1:0] key_vec;
   logic [DEPTH-1:0]            valid_vec;
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         key_vec[i]   = e_key[i];
         valid_vec[i] = e_flg[i].valid;
      end
   end

   logic [KEY_W-1:0] rd_key, wr_key;
   assign rd_key = {rd_layer, rd_array, rd_row, rd_col};
   assign wr_key = {wr_layer, wr_array, wr_row, wr_col};

   logic [DEPTH-1:0] rd_hits, wr_hits, rd_grant, wr_grant;
   logic             rd_any, wr_any;

   rcam_match #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_rd_match (
      .key(rd_key), .keys(key_vec), .valid(valid_vec), .hits(rd_hits));
   rcam_match #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_wr_match (
      .key(wr_key), .keys(key_vec), .valid(valid_vec), .hits(wr_hits));
   rcam_prio #(.DEPTH(DEPTH)) u_rd_prio (
      .req(rd_hits), .grant(rd_grant), .any(rd_any));
   rcam_prio #(.DEPTH(DEPTH)) u_wr_prio (
      .req(wr_hits), .grant(wr_grant), .any(wr_any));

   assign full = (fill_cnt == CNT_W'(DEPTH));

   // Entry update: load into next free slot, spare write, flag set.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_cnt <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_key[i]   <= '0;
            e_ml[i]    <= '0;
            e_mask[i]  <= '0;
            e_spare[i] <= '0;
            e_flg[i]   <= '0;
         end
      end else begin
         if (ld_valid && !full) fill_cnt <= fill_cnt + 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            if (ld_valid && !full && (fill_cnt == CNT_W'(i))) begin
               e_key[i]       <= {ld_layer, ld_array, ld_row, ld_col};
               e_ml[i]        <= ld_mlayer;
               e_mask[i]      <= ld_mask;
               e_spare[i]     <= '0;
               e_flg[i].valid <= 1'b1;
               e_flg[i].rmf   <= ld_rmf;
               e_flg[i].cmf   <= ld_cmf;
            end else begin
               if (wr_valid && wr_any && wr_grant[i]) e_spare[i] <= wr_data;
               if (fl_set_rmf && (fl_idx == IDX_W'(i))) e_flg[i].rmf <= 1'b1;
               if (fl_set_cmf && (fl_idx == IDX_W'(i))) e_flg[i].cmf <= 1'b1;
            end
         end
      end
   end

   // Selected spare contents for the read
   logic [DATA_W-1:0] sel_spare, sel_mask;
   always_comb begin
      sel_spare = '0;
      sel_mask  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_grant[i]) begin
            sel_spare = sel_spare | e_spare[i];
            sel_mask  = sel_mask  | e_mask[i];
         end
      end
   end

   // Lookup result registered to line up with the array word
   logic [DATA_W-1:0] q_spare, q_mask;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         q_spare   <= '0;
         q_mask    <= '0;
      end else begin
         out_valid <= rd_valid;
         out_hit   <= rd_valid && rd_any;
         q_spare   <= sel_spare;
         q_mask    <= sel_mask;
      end
   end

   rcam_merge #(.DATA_W(DATA_W)) u_merge (
      .hit(out_hit), .arr_word(arr_data), .spare_word(q_spare),
      .mask(q_mask), .merged(out_data));

   // Flag readout
   always_comb begin
      fl_valid  = 1'b0;
      fl_rmf    = 1'b0;
      fl_cmf    = 1'b0;
      fl_mlayer = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (fl_idx == IDX_W'(i)) begin
            fl_valid  = e_flg[i].valid;
            fl_rmf    = e_flg[i].rmf;
            fl_cmf    = e_flg[i].cmf;
            fl_mlayer = e_ml[i];
         end
      end
   end

endmodule

// File: rtl/rcam_checker.sv
module rcam_checker #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid,
   input logic              out_valid,
   input logic              out_hit,
   input logic [DATA_W-1:0] out_data,
   input logic [DATA_W-1:0] arr_data,
   input logic              ld_valid,
   input logic              full,
   input logic [IDX_W-1:0]  fl_idx,
   input logic              fl_set_rmf,
   input logic              fl_set_cmf,
   input logic              fl_rmf,
   input logic              fl_cmf
);

   AST_OUT_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(rd_valid)));                              // R10
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> out_valid);                                                        // R3
   AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> (out_data == arr_data));                           // R2
   AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> full);                                                                // R6
   AST_FULL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(ld_valid));                                              // R6
   AST_RMF_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fl_set_rmf) && !$past(ld_valid) && fl_idx == $past(fl_idx)) |-> fl_rmf); // R8
   AST_CMF_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fl_set_cmf) && !$past(ld_valid) && fl_idx == $past(fl_idx)) |-> fl_cmf); // R8

endmodule

bind spare_merge_cam rcam_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .out_valid(out_valid),
   .out_hit(out_hit), .out_data(out_data), .arr_data(arr_data),
   .ld_valid(ld_valid), .full(full), .fl_idx(fl_idx),
   .fl_set_rmf(fl_set_rmf), .fl_set_cmf(fl_set_cmf),
   .fl_rmf(fl_rmf), .fl_cmf(fl_cmf));

// File: tb/spare_merge_cam_test.sv
module spare_merge_cam_test;

   localparam int CLK_PERIOD = 10;
   localparam int LW = 3, AW = 6, RW = 10, CW = 10, DW = 16, DEPTH = 8, IW = 3;
   localparam int KW = LW + AW + RW + CW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic ld_valid = 0, ld_rmf = 0, ld_cmf = 0;
   logic [LW-1:0] ld_layer = 0, ld_mlayer = 0;
   logic [AW-1:0] ld_array = 0;
   logic [RW-1:0] ld_row = 0;
   logic [CW-1:0] ld_col = 0;
   logic [DW-1:0] ld_mask = 0;
   logic rd_valid = 0;
   logic [LW-1:0] rd_layer = 0;
   logic [AW-1:0] rd_array = 0;
   logic [RW-1:0] rd_row = 0;
   logic [CW-1:0] rd_col = 0;
   logic [DW-1:0] arr_data = 0;
   logic wr_valid = 0;
   logic [LW-1:0] wr_layer = 0;
   logic [AW-1:0] wr_array = 0;
   logic [RW-1:0] wr_row = 0;
   logic [CW-1:0] wr_col = 0;
   logic [DW-1:0] wr_data = 0;
   logic [IW-1:0] fl_idx = 0;
   logic fl_set_rmf = 0, fl_set_cmf = 0;
   logic full, out_valid, out_hit, fl_valid, fl_rmf, fl_cmf;
   logic [DW-1:0] out_data;
   logic [LW-1:0] fl_mlayer;

   spare_merge_cam #(.LAYER_W(LW), .ARRAY_W(AW), .ROW_W(RW), .COL_W(CW),
                     .DATA_W(DW), .DEPTH(DEPTH), .IDX_W(IW)) uut (.*);

   int checks = 0, errors = 0;

   // Reference model
   logic          m_v [DEPTH];
   logic [KW-1:0] m_key [DEPTH];
   logic [LW-1:0] m_ml [DEPTH];
   logic [DW-1:0] m_mask [DEPTH], m_spare [DEPTH];
   logic          m_rmf [DEPTH], m_cmf [DEPTH];
   int            m_cnt;
   logic          e_ov, e_hit;
   logic [DW-1:0] e_sp, e_mk;

   function automatic int find(logic [KW-1:0] k);
      for (int i = 0; i < DEPTH; i++) if (m_v[i] && m_key[i] == k) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < DEPTH; i++) begin
         m_v[i] = 0; m_key[i] = 0; m_ml[i] = 0; m_mask[i] = 0;
         m_spare[i] = 0; m_rmf[i] = 0; m_cmf[i] = 0;
      end
      m_cnt = 0; e_ov = 0; e_hit = 0; e_sp = 0; e_mk = 0;
   endtask

   task automatic model_edge();
      int k;
      e_ov = rd_valid; e_hit = 0;
      if (rd_valid) begin
         k = find({rd_layer, rd_array, rd_row, rd_col});
         if (k >= 0) begin e_hit = 1; e_sp = m_spare[k]; e_mk = m_mask[k]; end
      end
      if (wr_valid) begin
         k = find({wr_layer, wr_array, wr_row, wr_col});
         if (k >= 0) m_spare[k] = wr_data;
      end
      if (fl_set_rmf) m_rmf[fl_idx] = 1;
      if (fl_set_cmf) m_cmf[fl_idx] = 1;
      if (ld_valid && m_cnt < DEPTH) begin
         m_v[m_cnt] = 1; m_key[m_cnt] = {ld_layer, ld_array, ld_row, ld_col};
         m_ml[m_cnt] = ld_mlayer; m_mask[m_cnt] = ld_mask; m_spare[m_cnt] = 0;
         m_rmf[m_cnt] = ld_rmf; m_cmf[m_cnt] = ld_cmf; m_cnt++;
      end
   endtask

   task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk("R10", {tag, " out_valid"}, DW'(out_valid), DW'(e_ov));
      chk(tag, "out_hit", DW'(out_hit), DW'(e_hit));
      if (e_ov)
         chk(e_hit ? "R3" : "R2", {tag, " out_data"}, out_data,
             e_hit ? ((arr_data & ~e_mk) | (e_sp & e_mk)) : arr_data);
      chk("R6", {tag, " full"}, DW'(full), DW'(m_cnt == DEPTH));
      chk("R8", {tag, " fl_valid"}, DW'(fl_valid), DW'(m_v[fl_idx]));
      chk("R8", {tag, " fl_rmf"}, DW'(fl_rmf), DW'(m_rmf[fl_idx]));
      chk("R8", {tag, " fl_cmf"}, DW'(fl_cmf), DW'(m_cmf[fl_idx]));
      chk("R8", {tag, " fl_mlayer"}, DW'(fl_mlayer), DW'(m_ml[fl_idx]));
   endtask

   // Apply staged inputs for one edge, then check and return to idle.
   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
      ld_valid = 0; rd_valid = 0; wr_valid = 0; fl_set_rmf = 0; fl_set_cmf = 0;
   endtask

   task automatic load(int l, int a, int r, int c, int ml, logic [DW-1:0] mk, logic rf, logic cf);
      ld_valid = 1; ld_layer = LW'(l); ld_array = AW'(a); ld_row = RW'(r); ld_col = CW'(c);
      ld_mlayer = LW'(ml); ld_mask = mk; ld_rmf = rf; ld_cmf = cf;
   endtask

   task automatic rd(int l, int a, int r, int c, logic [DW-1:0] arr);
      rd_valid = 1; rd_layer = LW'(l); rd_array = AW'(a); rd_row = RW'(r); rd_col = CW'(c);
      arr_data = arr;
   endtask

   task automatic wr(int l, int a, int r, int c, logic [DW-1:0] d);
      wr_valid = 1; wr_layer = LW'(l); wr_array = AW'(a); wr_row = RW'(r); wr_col = CW'(c);
      wr_data = d;
   endtask

   logic done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: post-reset state for every entry
      for (int i = 0; i < DEPTH; i++) begin
         fl_idx = IW'(i);
         step("R1");
      end
      // R2: miss on empty table, several words
      rd(1, 2, 5, 7, 16'hA5A5); step("R2");
      rd(0, 0, 0, 0, 16'h0000); step("R2");
      rd(7, 63, 1023, 1023, 16'hFFFF); step("R2");
      // R6/R8: first load into entry 0
      fl_idx = 0;
      load(1, 2, 5, 7, 3, 16'h0010, 1, 0); step("R6");
      step("R8");
      // R9: spare starts at zero
      rd(1, 2, 5, 7, 16'hFFFF); step("R9");
      // R7/R3: write then merge with several array words
      wr(1, 2, 5, 7, 16'h1234); step("R7");
      rd(1, 2, 5, 7, 16'h0000); step("R3");
      rd(1, 2, 5, 7, 16'hFFFF); step("R3");
      wr(1, 2, 5, 7, 16'h0000); step("R7");
      rd(1, 2, 5, 7, 16'hFFFF); step("R3");
      // Second entry with a wide mask
      fl_idx = 1;
      load(4, 9, 100, 33, 6, 16'hF00F, 0, 1); step("R8");
      wr(4, 9, 100, 33, 16'hABCD); step("R7");
      rd(4, 9, 100, 33, 16'h5555); step("R3");
      // R4: one field differs -> miss; mapped layer value irrelevant
      rd(5, 9, 100, 33, 16'h1111); step("R4");
      rd(4, 8, 100, 33, 16'h2222); step("R4");
      rd(4, 9, 101, 33, 16'h3333); step("R4");
      rd(4, 9, 100, 32, 16'h4444); step("R4");
      rd(6, 9, 100, 33, 16'h6666); step("R4");
      // R5: duplicate of entry 0 location in entry 2
      fl_idx = 2;
      load(1, 2, 5, 7, 0, 16'h00FF, 0, 0); step("R5");
      wr(1, 2, 5, 7, 16'hFFFF); step("R5");
      rd(1, 2, 5, 7, 16'h0000); step("R5");
      // R7: non-matching write leaves all spares alone
      wr(2, 2, 2, 2, 16'h5A5A); step("R7");
      rd(4, 9, 100, 33, 16'h0000); step("R7");
      rd(1, 2, 5, 7, 16'h0000); step("R7");
      // R7: read and write in the same cycle sees the old word
      wr(4, 9, 100, 33, 16'h0F0F); rd(4, 9, 100, 33, 16'h0000); step("R7");
      rd(4, 9, 100, 33, 16'h0000); step("R7");
      // R8: flag set through the analysis port
      fl_idx = 1; fl_set_rmf = 1; step("R8");
      fl_idx = 2; fl_set_cmf = 1; step("R8");
      fl_idx = 0; fl_set_cmf = 1; fl_set_rmf = 1; step("R8");
      // R6: fill remaining entries
      for (int i = 3; i < DEPTH; i++) begin
         fl_idx = IW'(i);
         load(3, i, i * 10, i, i % 8, DW'(1 << i), i[0], ~i[0]); step("R6");
      end
      // R6: load while full is dropped, and its location misses
      load(7, 7, 7, 7, 7, 16'hFFFF, 1, 1); step("R6");
      rd(7, 7, 7, 7, 16'h1357); step("R6");
      rd(3, 5, 50, 5, 16'hFFFF); step("R3");
      // R10: back-to-back reads then idle
      rd(3, 6, 60, 6, 16'h0000); step("R10");
      rd(1, 2, 5, 7, 16'h8001); step("R10");
      step("R10");
      step("R10");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule